// File: doc/BRIEF.md
# Masked breakpoint address comparator

This block watches every bus cycle and raises a break request when the cycle's address equals a programmed break address. A 3-bit mask code removes a group of low-order address bits from the comparison. The code selects 0, 1, 2, 3, 4, 8, 12 or 16 ignored bits, so a single setting can cover a byte, a word, a small table or a whole 64 KiB window.

A master-select bit decides which bus masters can trigger a break. With the bit clear, only processor cycles can. With it set, data-transfer-controller cycles can as well. Any other master never triggers a break.

Software programs the break address and the control fields through a small synchronous write port. The bus side presents an address, a master identity and a cycle-valid strobe. The block answers with a registered break pulse one clock after each qualifying cycle.

Top module: `brk_addr_match`

## Requirements
- R1: Reset (`rst`, synchronous, active-high) clears the break address, the mask code, the master-select bit and `brk_pulse` to zero.
- R2: When `cfg_wr` is high on a rising edge, the write is captured at that edge. With `cfg_sel`=0, `cfg_wdata[23:0]` loads the break address. With `cfg_sel`=1, `cfg_wdata[2:0]` loads the mask code and `cfg_wdata[3]` loads the master-select bit. A bus cycle presented in the same clock as a write is judged with the settings held before that write.
- R3: With mask code 000, all 24 address bits take part in the comparison, so a difference in bit 0 or in bit 23 prevents a break.
- R4: Mask codes 001, 010 and 011 ignore bit 0, bits 1:0 and bits 2:0 respectively.
- R5: Mask codes 100, 101, 110 and 111 ignore bits 3:0, 7:0, 11:0 and 15:0 respectively.
- R6: Ignored bits match any bus value. Every bit above the ignored group must equal the break address. An address equal to the break address always matches.
- R7: `bus_mstr` encodes 00 for the processor, 01 for the data-transfer controller, and 10 or 11 for other masters. With master-select 0, only processor cycles can break.
- R8: With master-select 1, processor and data-transfer-controller cycles can break. Cycles from masters 10 and 11 never break, whatever the select setting.
- R9: A cycle with `bus_valid` low never produces a break.
- R10: `brk_pulse` goes high in the clock after a qualifying cycle and stays high for that one clock only, unless the next cycle also qualifies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the break address, 1 selects the control fields |
| cfg_wdata | input | 24 | Write data |
| bus_addr | input | 24 | Address of the current bus cycle |
| bus_mstr | input | 2 | Identity of the bus master for the current cycle |
| bus_valid | input | 1 | High when the current bus cycle is real |
| brk_pulse | output | 1 | Registered break request |

## Verification
A wrong mask code decode appears at `brk_pulse` one clock after the bus cycle. Either an address that differs just inside the ignored group fails to break, or an address that differs one bit above it breaks anyway. For this reason every code is driven with both neighbouring bits. A corrupt break address or select bit shows up the same way, one cycle after the first affected access. A stuck output register is exposed by the low cycle that must follow each pulse.

// File: rtl/bam_pkg.sv
package bam_pkg;

   localparam int unsigned CODE_W = 3;

   typedef enum logic [1:0] {
      MST_CPU  = 2'b00,
      MST_DTC  = 2'b01,
      MST_OTH2 = 2'b10,
      MST_OTH3 = 2'b11
   } bam_mstr_e;

   // number of low-order address bits left out of the comparison
   function automatic int unsigned bam_ign_bits(input logic [CODE_W-1:0] code);
      int unsigned c;
      c = int'(code);
      if (c < 4) return c;
      return (c - 3) * 4;
   endfunction

endpackage

// File: rtl/bam_cfg_regs.sv
module bam_cfg_regs #(
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned CODE_W = bam_pkg::CODE_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_wr,
   input  logic              cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wdata,
   output logic [ADDR_W-1:0] brk_addr_q,
   output logic [CODE_W-1:0] mask_code_q,
   output logic              dtc_ok_q
);
   localparam int unsigned SEL_BIT = CODE_W;

   if (ADDR_W <= SEL_BIT) begin : g_bad_width
      $error("bam_cfg_regs: ADDR_W too narrow for control fields");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         brk_addr_q  <= '0;
         mask_code_q <= '0;
         dtc_ok_q    <= 1'b0;
      end else if (cfg_wr) begin
         if (!cfg_sel) begin
            brk_addr_q <= cfg_wdata;
         end else begin
            mask_code_q <= cfg_wdata[CODE_W-1:0];
            dtc_ok_q    <= cfg_wdata[SEL_BIT];
         end
      end
   end

   // R2: an address write is visible on the next cycle
   a_r2_addr_load: assert property (@(posedge clk) disable iff (rst)
      (cfg_wr && !cfg_sel) |=> (brk_addr_q == $past(cfg_wdata)));

   // R1: reset leaves every field cleared
   a_r1_cfg_clear: assert property (@(posedge clk)
      rst |=> (brk_addr_q == '0 && mask_code_q == '0 && !dtc_ok_q));

endmodule

// File: rtl/bam_mask_decode.sv
module bam_mask_decode #(
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned CODE_W = bam_pkg::CODE_W
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [ADDR_W-1:0] care_o
);
   localparam int unsigned MAX_IGN = 16;

   if (ADDR_W <= MAX_IGN) begin : g_bad_width
      $error("bam_mask_decode: ADDR_W must exceed the widest ignored group");
   end
   if (CODE_W != 3) begin : g_bad_code
      $error("bam_mask_decode: mask code must be 3 bits wide");
   end

   int unsigned ign;
   assign ign = bam_pkg::bam_ign_bits(code_i);

   for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
      if (i >= MAX_IGN) begin : g_always
         assign care_o[i] = 1'b1;
      end else begin : g_coded
         assign care_o[i] = (i >= ign);
      end
   end

endmodule

// File: rtl/bam_qualify.sv
module bam_qualify #(
   parameter int unsigned ADDR_W   = 24,
   parameter bit          FLAT_CMP = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_mstr,
   input  logic              bus_valid,
   input  logic [ADDR_W-1:0] brk_addr,
   input  logic [ADDR_W-1:0] care,
   input  logic              dtc_ok,
   output logic              hit
);
   import bam_pkg::*;

   logic addr_eq;
   logic mstr_ok;

   if (FLAT_CMP) begin : g_flat
      assign addr_eq = ((bus_addr ^ brk_addr) & care) == '0;
   end else begin : g_bitwise
      logic [ADDR_W-1:0] bit_ok;
      for (genvar i = 0; i < ADDR_W; i++) begin : g_b
         assign bit_ok[i] = !care[i] || (bus_addr[i] == brk_addr[i]);
      end
      assign addr_eq = &bit_ok;
   end

   always_comb begin
      unique case (bam_mstr_e'(bus_mstr))
         MST_CPU: mstr_ok = 1'b1;
         MST_DTC: mstr_ok = dtc_ok;
         default: mstr_ok = 1'b0;
      endcase
   end

   assign hit = bus_valid && addr_eq && mstr_ok;

   // R6: the ignored group is always a contiguous run at the bottom
   a_r6_mask_contig: assert property (@(posedge clk) disable iff (rst)
      (((~care) + ADDR_W'(1)) & (~care)) == '0);

   // R5: the top bit is never ignored
   a_r5_top_kept: assert property (@(posedge clk) disable iff (rst)
      care[ADDR_W-1]);

endmodule

// File: rtl/brk_addr_match.sv
module brk_addr_match #(
   parameter int unsigned ADDR_W   = 24,
   parameter bit          FLAT_CMP = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_wr,
   input  logic              cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_mstr,
   input  logic              bus_valid,
   output logic              brk_pulse
);
   import bam_pkg::*;

   logic [ADDR_W-1:0] brk_addr_q;
   logic [CODE_W-1:0] mask_code_q;
   logic              dtc_ok_q;
   logic [ADDR_W-1:0] care;
   logic              hit;

   bam_cfg_regs #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_regs (
      .clk         (clk),
      .rst         (rst),
      .cfg_wr      (cfg_wr),
      .cfg_sel     (cfg_sel),
      .cfg_wdata   (cfg_wdata),
      .brk_addr_q  (brk_addr_q),
      .mask_code_q (mask_code_q),
      .dtc_ok_q    (dtc_ok_q)
   );

   bam_mask_decode #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_mask (
      .code_i (mask_code_q),
      .care_o (care)
   );

   bam_qualify #(.ADDR_W(ADDR_W), .FLAT_CMP(FLAT_CMP)) u_qual (
      .clk       (clk),
      .rst       (rst),
      .bus_addr  (bus_addr),
      .bus_mstr  (bus_mstr),
      .bus_valid (bus_valid),
      .brk_addr  (brk_addr_q),
      .care      (care),
      .dtc_ok    (dtc_ok_q),
      .hit       (hit)
   );

   always_ff @(posedge clk) begin
      if (rst) brk_pulse <= 1'b0;
      else     brk_pulse <= hit;
   end

   // R1: output cleared by reset
   a_r1_out_clear: assert property (@(posedge clk) rst |=> !brk_pulse);

   // R9: idle bus never breaks
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      !bus_valid |=> !brk_pulse);

   // R8: foreign masters never break
   a_r8_foreign_quiet: assert property (@(posedge clk) disable iff (rst)
      (bus_valid && bus_mstr[1]) |=> !brk_pulse);

   // R7: controller cycles are ignored while the select bit is clear
   a_r7_cpu_only: assert property (@(posedge clk) disable iff (rst)
      (bus_mstr == 2'b01 && !dtc_ok_q) |=> !brk_pulse);

   // R6 / R10: an exact processor hit always pulses next cycle
   a_r10_exact_hit: assert property (@(posedge clk) disable iff (rst)
      (bus_valid && bus_mstr == 2'b00 && bus_addr == brk_addr_q) |=> brk_pulse);

endmodule

// File: tb/test_brk_addr_match.sv
module test_brk_addr_match;

   localparam int unsigned AW = 24;
   localparam logic [AW-1:0] BASE = 24'hA5C3E7;

   // {mask code, flipped bit}: each code with the bit just inside and just outside its group
   localparam logic [7:0] VEC [16] = '{
      {3'd0, 5'd0},  {3'd0, 5'd23},
      {3'd1, 5'd0},  {3'd1, 5'd1},
      {3'd2, 5'd1},  {3'd2, 5'd2},
      {3'd3, 5'd2},  {3'd3, 5'd3},
      {3'd4, 5'd3},  {3'd4, 5'd4},
      {3'd5, 5'd7},  {3'd5, 5'd8},
      {3'd6, 5'd11}, {3'd6, 5'd12},
      {3'd7, 5'd15}, {3'd7, 5'd16}
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cfg_wr = 1'b0;
   logic          cfg_sel = 1'b0;
   logic [AW-1:0] cfg_wdata = '0;
   logic [AW-1:0] bus_addr = '0;
   logic [1:0]    bus_mstr = 2'b00;
   logic          bus_valid = 1'b0;
   logic          brk_pulse;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   brk_addr_match i_brk_addr_match (
      .clk       (clk),
      .rst       (rst),
      .cfg_wr    (cfg_wr),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .bus_addr  (bus_addr),
      .bus_mstr  (bus_mstr),
      .bus_valid (bus_valid),
      .brk_pulse (brk_pulse)
   );

   function automatic logic ref_hit(input logic [2:0] code, input int unsigned flip);
      int unsigned ign;
      ign = (code < 3'd4) ? int'(code) : (int'(code) - 3) * 4;
      return flip < ign;
   endfunction

   task automatic chk(input logic act, input logic exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: brk_pulse=%b expected %b", tag, act, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [AW-1:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic probe(input logic [AW-1:0] a, input logic [1:0] m, input logic v,
                        input logic exp, input string tag);
      @(negedge clk);
      bus_addr = a; bus_mstr = m; bus_valid = v;
      @(posedge clk); #1;
      chk(brk_pulse, exp, tag);
      @(negedge clk);
      bus_valid = 1'b0;
      @(posedge clk); #1;
      chk(brk_pulse, 1'b0, "R10 pulse lasts one clock");
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(4 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 chk(brk_pulse, 1'b0, "R1 output low in reset");
      @(negedge clk); rst = 1'b0;

      // R1: cleared registers -> address 0, full compare, processor only
      probe(24'h000000, 2'b00, 1'b1, 1'b1, "R1 reset address is zero");
      probe(24'h000000, 2'b01, 1'b1, 1'b0, "R7 reset select blocks controller");

      // table walk over all mask codes (R3 R4 R5 R6)
      wr(1'b0, BASE);
      for (int k = 0; k < 16; k++) begin
         logic [2:0] code;
         int unsigned flip;
         code = VEC[k][7:5];
         flip = int'(VEC[k][4:0]);
         wr(1'b1, {20'd0, 1'b0, code});
         probe(BASE ^ (24'd1 << flip), 2'b00, 1'b1, ref_hit(code, flip),
               $sformatf("R3/R4/R5/R6 code %0d bit %0d", code, flip));
      end

      // R6: code 111 ignores the whole low half-word
      probe({BASE[23:16], 16'h0000}, 2'b00, 1'b1, 1'b1, "R6 low group any value");

      // R9: invalid cycle
      probe(BASE, 2'b00, 1'b0, 1'b0, "R9 strobe low");

      // R7 / R8 master qualification
      wr(1'b1, {20'd0, 1'b0, 3'd0});
      probe(BASE, 2'b01, 1'b1, 1'b0, "R7 controller blocked");
      probe(BASE, 2'b00, 1'b1, 1'b1, "R7 processor allowed");
      wr(1'b1, {20'd0, 1'b1, 3'd0});
      probe(BASE, 2'b01, 1'b1, 1'b1, "R8 controller allowed");
      probe(BASE, 2'b10, 1'b1, 1'b0, "R8 master 10 blocked");
      probe(BASE, 2'b11, 1'b1, 1'b0, "R8 master 11 blocked");

      // R2: write in the same cycle as a bus access uses the old address
      wr(1'b0, 24'h00ABCD);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_wdata = 24'h00ABCE;
      bus_addr = 24'h00ABCD; bus_mstr = 2'b00; bus_valid = 1'b1;
      @(posedge clk); #1;
      chk(brk_pulse, 1'b1, "R2 same-cycle access uses old address");
      @(negedge clk);
      cfg_wr = 1'b0; bus_addr = 24'h00ABCE;
      @(posedge clk); #1;
      chk(brk_pulse, 1'b1, "R2 new address active");
      @(negedge clk);
      bus_addr = 24'h00ABCD;
      @(posedge clk); #1;
      chk(brk_pulse, 1'b0, "R2 old address gone");
      @(negedge clk); bus_valid = 1'b0;

      // R1: mid-run reset clears address and select
      wr(1'b1, {20'd0, 1'b1, 3'd7});
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      probe(24'h00ABCE, 2'b00, 1'b1, 1'b0, "R1 address cleared");
      probe(24'h000000, 2'b01, 1'b1, 1'b0, "R1 select cleared");
      probe(24'h000001, 2'b00, 1'b1, 1'b0, "R1 mask code cleared");

      finish_run();
   end

endmodule